// File: doc/BRIEF.md
# Memory bank address selector

This block decides whether the address currently on the system bus belongs to one memory bank. It looks at the top five bits of the 18-bit byte address, which are bits 17 down to 13. It compares each of them with a five-bit bank code that is set when the system is configured. The bank is selected only when every bit being compared agrees. The bank code is the base address of the bank, written in binary, so a code bit of 0 demands a 0 on the matching address bit.

A capacity mode sets how large the bank is:
- **4K mode:** all five bits take part. The code then picks one of 32 banks of 4K words each, out of a 128K-word space.
- **8K mode:** address bit 13 always counts as a match, so a single bank spans 8K words.

A bus power-low indication also feeds the match. While the supply is below its limits, no bank is selected.

Address bit 1 is not decoded. It is passed straight through to the word address register.

The block has no clock and no state. The code and the mode are static inputs, and a change to either shows on the select output at once.

Top module: `bank_window_decode`

## Requirements
- R1: In 4K mode (`wide_mode`=0), with `pwr_low`=0, `bank_sel` is 1 whenever `bus_addr_hi` equals `bank_code`. Bit 0 of both fields corresponds to address bit 13, and bit 4 to address bit 17.
- R2: In either mode, `bank_sel` is 0 whenever bits 4..1 of `bus_addr_hi` (address bits 17..14) differ from bits 4..1 of `bank_code`.
- R3: In 8K mode (`wide_mode`=1), address bit 13 is ignored. With `pwr_low`=0 and bits 4..1 equal, `bank_sel` is 1 whatever `bus_addr_hi[0]` and `bank_code[0]` are.
- R4: In 4K mode, a difference between `bus_addr_hi[0]` and `bank_code[0]` alone makes `bank_sel` 0.
- R5: While `pwr_low`=1 (supply below limits), `bank_sel` is 0 for every address, code and mode.
- R6: `word_addr_b1` always equals `bus_addr_b1`, whatever the other inputs are.
- R7: In 4K mode, with code n, the bank answers exactly for byte addresses n×8192 to n×8192+8190. In 8K mode it answers for (n with bit 0 cleared)×8192 to that base+16382.
- R8: A change of `bank_code` or `wide_mode` alone is reflected on `bank_sel` without any clock or latching step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bus_addr_hi | input | 5 | Bus byte address bits 17..13 (bit 0 = address bit 13) |
| bus_addr_b1 | input | 1 | Bus byte address bit 1 |
| bank_code | input | 5 | Configured bank code, the binary form of the bank base address bits 17..13 |
| wide_mode | input | 1 | 1 = 8K-word bank (bit 13 not compared), 0 = 4K-word bank |
| pwr_low | input | 1 | 1 while the supply voltages are below limits |
| bank_sel | output | 1 | 1 when the address falls inside this bank |
| word_addr_b1 | output | 1 | Address bit 1 forwarded to the word address register |

## Verification
The bench sweeps every bank code against every upper address field, in both modes and with power good and power low. Each address is built as a full byte address, using offsets at the bottom and top of a 4K window and inside it. The expected select comes from an arithmetic range comparison.

The sweep is aimed at these faults:
- A design that still compares bit 13 in 8K mode would drop the upper half of each 8K bank.
- A design that masks bit 13 in 4K mode would answer for a neighbouring bank.
- A comparator with an inverted polarity would select the bank whose address is the complement of its code.
- A design that ignores the power-low input would select banks while the supply is failing.

The bit-1 forwarding path is checked at every step, so a stuck or swapped path shows up.

// File: rtl/bank_window_decode.sv
module bank_window_decode #(
  parameter int FIELD_W   = 5,
  parameter int WIDE_DROP = 1
) (
  input  logic [FIELD_W-1:0] bus_addr_hi,
  input  logic               bus_addr_b1,
  input  logic [FIELD_W-1:0] bank_code,
  input  logic               wide_mode,
  input  logic               pwr_low,
  output logic               bank_sel,
  output logic               word_addr_b1
);

  logic [FIELD_W-1:0] bit_eq;

  genvar i;
  generate
    for (i = 0; i < FIELD_W; i++) begin : g_cmp
      if (i < WIDE_DROP) begin : g_masked
        assign bit_eq[i] = wide_mode | ~(bus_addr_hi[i] ^ bank_code[i]);
      end else begin : g_plain
        assign bit_eq[i] = ~(bus_addr_hi[i] ^ bank_code[i]);
      end
    end
  endgenerate

  assign bank_sel     = &bit_eq & ~pwr_low;
  assign word_addr_b1 = bus_addr_b1;

endmodule

// File: rtl/bank_window_decode_chk.sv
module bank_window_decode_chk #(
  parameter int FIELD_W = 5
) (
  input logic [FIELD_W-1:0] bus_addr_hi,
  input logic [FIELD_W-1:0] bank_code,
  input logic               wide_mode,
  input logic               pwr_low,
  input logic               bank_sel
);

  always_comb begin
    if (!$isunknown({bus_addr_hi, bank_code, wide_mode, pwr_low, bank_sel})) begin
      if (pwr_low)
        p_pwr_low_blocks_r5: assert (!bank_sel);
      if (!pwr_low && !wide_mode && bus_addr_hi == bank_code)
        p_full_match_r1: assert (bank_sel);
      if (bus_addr_hi[FIELD_W-1:1] != bank_code[FIELD_W-1:1])
        p_upper_mismatch_r2: assert (!bank_sel);
      if (!pwr_low && wide_mode && bus_addr_hi[FIELD_W-1:1] == bank_code[FIELD_W-1:1])
        p_wide_ignores_low_r3: assert (bank_sel);
      if (!wide_mode && bus_addr_hi[0] != bank_code[0])
        p_narrow_low_bit_r4: assert (!bank_sel);
    end
  end

endmodule

bind bank_window_decode bank_window_decode_chk #(.FIELD_W(FIELD_W)) u_chk (
  .bus_addr_hi(bus_addr_hi),
  .bank_code  (bank_code),
  .wide_mode  (wide_mode),
  .pwr_low    (pwr_low),
  .bank_sel   (bank_sel)
);

// File: tb/tb_bank_window_decode.sv
module tb_bank_window_decode;
  localparam int CLK_PERIOD = 10;
  localparam int FW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [FW-1:0] bus_addr_hi = '0;
  logic          bus_addr_b1 = 1'b0;
  logic [FW-1:0] bank_code   = '0;
  logic          wide_mode   = 1'b0;
  logic          pwr_low     = 1'b1;
  logic          bank_sel;
  logic          word_addr_b1;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  bank_window_decode dut (
    .bus_addr_hi (bus_addr_hi),
    .bus_addr_b1 (bus_addr_b1),
    .bank_code   (bank_code),
    .wide_mode   (wide_mode),
    .pwr_low     (pwr_low),
    .bank_sel    (bank_sel),
    .word_addr_b1(word_addr_b1)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%b expected=%b (code=%0d field=%0d wide=%b plow=%b)",
               req, act, exp, bank_code, bus_addr_hi, wide_mode, pwr_low);
    end
  endtask

  function automatic logic ref_sel(input int addr, input int code, input bit wide, input bit plow);
    int base, top;
    if (wide) begin
      base = (code & ~1) * 8192;
      top  = base + 16382;
    end else begin
      base = code * 8192;
      top  = base + 8190;
    end
    return !plow && addr >= base && addr <= top;
  endfunction

  initial begin
    int offs[4] = '{0, 2, 4094, 8190};
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R5 reset-state", bank_sel, 1'b0);

    for (int m = 0; m < 2; m++)
      for (int c = 0; c < 32; c++)
        for (int f = 0; f < 32; f++)
          for (int p = 0; p < 2; p++)
            for (int o = 0; o < 4; o++) begin
              int addr;
              logic e;
              addr = f * 8192 + offs[o];
              @(posedge clk);
              #1;
              wide_mode   = m[0];
              bank_code   = c[FW-1:0];
              bus_addr_hi = addr[17:13];
              bus_addr_b1 = addr[1];
              pwr_low     = p[0];
              @(negedge clk);
              e = ref_sel(addr, c, m[0], p[0]);
              if (p != 0)
                check("R5", bank_sel, 1'b0);
              else if (m == 0 && f == c)
                check("R1", bank_sel, 1'b1);
              else if ((f >> 1) != (c >> 1))
                check("R2", bank_sel, 1'b0);
              else if (m != 0)
                check("R3", bank_sel, 1'b1);
              else
                check("R4", bank_sel, 1'b0);
              check("R7", bank_sel, e);
              check("R6", word_addr_b1, addr[1]);
            end

    // R8: reconfiguration seen without any clocking step
    @(posedge clk); #1;
    pwr_low = 1'b0; wide_mode = 1'b0; bus_addr_hi = 5'd5; bank_code = 5'd4;
    #1 check("R8 before", bank_sel, 1'b0);
    wide_mode = 1'b1;
    #1 check("R8 mode", bank_sel, 1'b1);
    bank_code = 5'd9;
    #1 check("R8 code", bank_sel, 1'b0);

    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule